// File: doc/BRIEF.md
# Asynchronous SRAM controller

This block lets a synchronous host reach an external asynchronous static RAM with 128K locations of 8 bits each. The host offers one request at a time on a valid/ready channel. A request carries a write flag, a 17-bit location and a write byte. The controller then plays the strobe sequence the memory needs, with every interval counted in whole clock cycles. A read returns its byte together with a one-cycle completion pulse, and a write also ends with a completion pulse.

The memory is enabled only while its low-true select is low and its high-true select is high. In every other phase both selects sit at their inactive levels, so the device rests in standby. Each minimum interval is looked up per speed grade (70 ns or 100 ns) in nanoseconds and rounded up to whole periods of the `CLK_PERIOD_NS` parameter. The data bus is split into an output byte, an output enable and an input byte, which a pad cell at chip level combines into the shared tri-state bus.

Back-pressure rules:
- A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high.
- The host may hold `req_valid` high across cycles. While `req_ready` is low, the request inputs are not looked at.
- The response side has no ready. The host must take `rsp_valid` in the cycle it appears.

Top module: `sram_ctl`

## Requirements
- R1: Out of reset and whenever `req_ready` is high, the memory-side pins rest in this state: `mem_cs_n`=1, `mem_cs`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0.
- R2: `req_ready` is high only when no access is in progress. After a request is taken, `req_ready` stays low until the access and its trailing phase have finished. Request inputs changed while `req_ready` is low have no effect on the memory pins.
- R3: A read (`req_write`=0) holds both selects active, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0 for RD = ceil(max(read cycle, address access)/T) cycles, where T is `CLK_PERIOD_NS`; at 70 ns and T=10 this is 7. `mem_dq_i` is sampled at the edge that ends this phase, and `rsp_valid` is then high for exactly one cycle with that byte on `rsp_rdata`.
- R4: After a read phase, the controller spends TURN = ceil(output-release time/T) cycles with all strobes inactive and `mem_dq_oe`=0 before `req_ready` returns. The output-release time is 25 ns at 70 ns and 30 ns at 100 ns; at 70 ns and T=10, TURN is 3.
- R5: A write (`req_write`=1) holds both selects active, `mem_we_n`=0, `mem_oe_n`=1 and `mem_dq_oe`=1 for WA cycles, with the request byte on `mem_dq_o`. WA is the largest of the ceilings of the write pulse, the select-to-end time, the address-to-end time and the data setup. The 70 ns values are 55/60/60/30 ns and the 100 ns values are 70/80/80/40 ns; at 70 ns and T=10, WA is 6.
- R6: After a write phase, `mem_we_n` rises and both selects go inactive while `mem_dq_oe` stays high for REC = max(1, ceil(write cycle/T) − WA) cycles; at 70 ns and T=10, REC is 1. `rsp_valid` then pulses for one cycle, in the same cycle that `req_ready` returns.
- R7: `mem_addr` and `mem_dq_o` hold the accepted request's values for the whole access.
- R8: `mem_dq_oe` never rises within TURN cycles after `mem_oe_n` was last low, so the controller never drives the bus while the memory may still be driving it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every interval counts its periods |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Memory location |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte returned by the last read |
| mem_cs_n | output | 1 | Low-true memory select |
| mem_cs | output | 1 | High-true memory select |
| mem_oe_n | output | 1 | Memory output enable, low-true |
| mem_we_n | output | 1 | Memory write enable, low-true |
| mem_addr | output | 17 | Memory location bus |
| mem_dq_o | output | 8 | Byte driven toward the memory |
| mem_dq_oe | output | 1 | Enables the data-bus pad drivers |
| mem_dq_i | input | 8 | Byte seen on the data bus |

## Verification
Two events can fall in the same cycle. A write's completion pulse arrives in the cycle where `req_ready` returns, so a host holding `req_valid` high has its next request taken while `rsp_valid` is still high. The bench provokes this with back-to-back writes and write-then-read pairs. A cycle-accurate behavioural model judges the pulse, the acceptance and the start of the new strobe pattern in that cycle.

The second overlap is a write issued right after a read. There the end of the bus turnaround meets the controller's wish to drive. The bench's memory model keeps driving for the release time after its output enable drops. It flags any cycle in which both sides drive the bus together.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_READ  = 3'd1,
    PH_TURN  = 3'd2,
    PH_WRITE = 3'd3,
    PH_WREC  = 3'd4
  } phase_e;

  // Minimum intervals the memory asks for, in nanoseconds.
  typedef enum int unsigned {
    T_RD_CYCLE, T_ADDR_ACC, T_RELEASE, T_WR_CYCLE,
    T_SEL_END, T_ADDR_END, T_WE_PULSE, T_DATA_SETUP
  } tmin_e;

  function automatic int unsigned min_ns(input int unsigned grade, input tmin_e which);
    int unsigned v;
    if (grade == 0) begin
      case (which)
        T_RD_CYCLE, T_ADDR_ACC, T_WR_CYCLE: v = 70;
        T_RELEASE:                          v = 25;
        T_SEL_END, T_ADDR_END:              v = 60;
        T_WE_PULSE:                         v = 55;
        default:                            v = 30;
      endcase
    end else begin
      case (which)
        T_RD_CYCLE, T_ADDR_ACC, T_WR_CYCLE: v = 100;
        T_RELEASE:                          v = 30;
        T_SEL_END, T_ADDR_END:              v = 80;
        T_WE_PULSE:                         v = 70;
        default:                            v = 40;
      endcase
    end
    return v;
  endfunction

  // Ceiling division; any nonzero time becomes at least one cycle.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
    if (ns == 0) return 0;
    return (ns + period - 1) / period;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int unsigned RD_N   = 7,
  parameter int unsigned TURN_N = 3,
  parameter int unsigned WR_N   = 6,
  parameter int unsigned REC_N  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_write,
  output logic idle,
  output logic capture,
  output logic done,
  output logic cs_act,
  output logic oe_act,
  output logic we_act,
  output logic drv
);

  localparam int unsigned MAXN  = umax(umax(RD_N, TURN_N), umax(WR_N, REC_N));
  localparam int unsigned CNT_W = $clog2(MAXN + 1);

  phase_e            ph_q, ph_nxt;
  logic              load, expired;
  logic [CNT_W-1:0]  load_val;

  sram_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  always_comb begin
    ph_nxt   = ph_q;
    load     = 1'b0;
    load_val = '0;
    case (ph_q)
      PH_IDLE: if (start) begin
        load = 1'b1;
        if (start_write) begin
          ph_nxt   = PH_WRITE;
          load_val = CNT_W'(WR_N - 1);
        end else begin
          ph_nxt   = PH_READ;
          load_val = CNT_W'(RD_N - 1);
        end
      end
      PH_READ: if (expired) begin
        ph_nxt   = PH_TURN;
        load     = 1'b1;
        load_val = CNT_W'(TURN_N - 1);
      end
      PH_TURN: if (expired) ph_nxt = PH_IDLE;
      PH_WRITE: if (expired) begin
        ph_nxt   = PH_WREC;
        load     = 1'b1;
        load_val = CNT_W'(REC_N - 1);
      end
      PH_WREC: if (expired) ph_nxt = PH_IDLE;
      default: ph_nxt = PH_IDLE;
    endcase
  end

  assign capture = (ph_q == PH_READ) && expired;
  assign idle    = (ph_q == PH_IDLE);

  // Strobes come straight from flops loaded with the next phase's decode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      done   <= 1'b0;
      cs_act <= 1'b0;
      oe_act <= 1'b0;
      we_act <= 1'b0;
      drv    <= 1'b0;
    end else begin
      ph_q   <= ph_nxt;
      done   <= capture || ((ph_q == PH_WREC) && expired);
      cs_act <= (ph_nxt == PH_READ) || (ph_nxt == PH_WRITE);
      oe_act <= (ph_nxt == PH_READ);
      we_act <= (ph_nxt == PH_WRITE);
      drv    <= (ph_nxt == PH_WRITE) || (ph_nxt == PH_WREC);
    end
  end

  // Cycles since output enable was last active, saturating at TURN_N.
  logic [CNT_W-1:0] quiet_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          quiet_q <= CNT_W'(TURN_N);
    else if (oe_act)                     quiet_q <= '0;
    else if (quiet_q < CNT_W'(TURN_N))   quiet_q <= quiet_q + 1'b1;
  end

  // R8
  drive_after_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv) |-> (quiet_q >= CNT_W'(TURN_N)));

  // R5
  we_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_act |-> (cs_act && !oe_act && drv));

  // R6
  data_held_on_we_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_act) |-> drv);

  // R3
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_act |-> (!drv && cs_act));

endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_wdata,
  output logic [DATA_W-1:0] out_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_addr  <= '0;
      out_wdata <= '0;
    end else if (accept) begin
      out_addr  <= in_addr;
      out_wdata <= in_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out_rdata <= '0;
    else if (capture) out_rdata <= dq_in;
  end

  // R2
  accept_capture_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && capture));

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned SPEED_GRADE   = 0,
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned RD_N = umax(
    ns_to_cyc(min_ns(SPEED_GRADE, T_RD_CYCLE), CLK_PERIOD_NS),
    ns_to_cyc(min_ns(SPEED_GRADE, T_ADDR_ACC), CLK_PERIOD_NS));
  localparam int unsigned TURN_N = umax(1,
    ns_to_cyc(min_ns(SPEED_GRADE, T_RELEASE), CLK_PERIOD_NS));
  localparam int unsigned WR_N = umax(
    umax(ns_to_cyc(min_ns(SPEED_GRADE, T_WE_PULSE), CLK_PERIOD_NS),
         ns_to_cyc(min_ns(SPEED_GRADE, T_SEL_END),  CLK_PERIOD_NS)),
    umax(ns_to_cyc(min_ns(SPEED_GRADE, T_ADDR_END), CLK_PERIOD_NS),
         ns_to_cyc(min_ns(SPEED_GRADE, T_DATA_SETUP), CLK_PERIOD_NS)));
  localparam int unsigned WC_N  = ns_to_cyc(min_ns(SPEED_GRADE, T_WR_CYCLE), CLK_PERIOD_NS);
  localparam int unsigned REC_N = (WC_N > WR_N) ? (WC_N - WR_N) : 1;

  logic idle, accept, capture, done, cs_act, oe_act, we_act, drv;

  assign req_ready = idle;
  assign accept    = req_valid && idle;

  sram_ctl_seq #(
    .RD_N   (RD_N),
    .TURN_N (TURN_N),
    .WR_N   (WR_N),
    .REC_N  (REC_N)
  ) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .start_write (req_write),
    .idle        (idle),
    .capture     (capture),
    .done        (done),
    .cs_act      (cs_act),
    .oe_act      (oe_act),
    .we_act      (we_act),
    .drv         (drv)
  );

  sram_ctl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .in_addr   (req_addr),
    .in_wdata  (req_wdata),
    .capture   (capture),
    .dq_in     (mem_dq_i),
    .out_addr  (mem_addr),
    .out_wdata (mem_dq_o),
    .out_rdata (rsp_rdata)
  );

  assign rsp_valid = done;
  assign mem_cs_n  = ~cs_act;
  assign mem_cs    = cs_act;
  assign mem_oe_n  = ~oe_act;
  assign mem_we_n  = ~we_act;
  assign mem_dq_oe = drv;

  // R1
  idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_oe));

  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

  // R3
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: tb/sram_ctl_tb_top.sv
module sram_ctl_tb_top;

  localparam int CLK_NS = 10;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  // Expected phase lengths for the 70 ns grade, worked from the requirements.
  localparam int E_RD   = cdiv(70, CLK_NS);
  localparam int E_TURN = cdiv(25, CLK_NS);
  localparam int E_WR   = cdiv(60, CLK_NS);
  localparam int E_REC  = (cdiv(70, CLK_NS) - E_WR > 1) ? cdiv(70, CLK_NS) - E_WR : 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [16:0] mem_addr;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i = 8'h00;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  sram_ctl #(.CLK_PERIOD_NS(CLK_NS), .SPEED_GRADE(0)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] blank_val(input int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'hA5;
  endfunction

  // Memory model and reference model state.
  logic [7:0] sram_mem [int];
  logic [7:0] exp_mem  [int];
  int rd_age = 0;
  int hz_left = 0;
  int m_mode = 0;   // 0 idle, 1 read, 2 turn, 3 write, 4 recovery
  int m_cnt  = 0;
  bit m_rsp = 0, m_rsp_rd = 0;
  logic [7:0]  m_rdata = '0;
  logic [16:0] m_addr = '0;
  logic [7:0]  m_wdata = '0;
  bit s_valid = 0, s_write = 0;
  logic [16:0] s_addr = '0;
  logic [7:0]  s_wdata = '0;

  always @(negedge clk) begin
    bit sel, rd_sel;
    string tag;
    logic [7:0] v;
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_rsp = 0; rd_age = 0; hz_left = 0;
    end else begin
      // Memory model: writes land while selected with write enable low.
      sel    = !mem_cs_n && mem_cs;
      rd_sel = sel && mem_we_n && !mem_oe_n;
      if (sel && !mem_we_n) sram_mem[int'(mem_addr)] = mem_dq_o;
      // R8: memory still drives for the release time after its read ends
      chk(!(mem_dq_oe && (rd_sel || hz_left > 0)), "R8", "bus contention",
          mem_dq_oe, 0);
      if (rd_sel) hz_left = E_TURN; else if (hz_left > 0) hz_left--;
      rd_age = rd_sel ? rd_age + 1 : 0;
      v = sram_mem.exists(int'(mem_addr)) ? sram_mem[int'(mem_addr)] : blank_val(int'(mem_addr));
      mem_dq_i = (rd_sel && rd_age >= E_RD) ? v : ~v;

      // Reference model step for the edge just passed.
      m_rsp = 0;
      if (m_mode == 0) begin
        if (s_valid) begin
          m_addr = s_addr; m_wdata = s_wdata;
          if (s_write) begin
            m_mode = 3; m_cnt = E_WR; exp_mem[int'(s_addr)] = s_wdata;
          end else begin
            m_mode = 1; m_cnt = E_RD;
          end
        end
      end else begin
        m_cnt--;
        if (m_cnt == 0) begin
          case (m_mode)
            1: begin
              m_mode = 2; m_cnt = E_TURN; m_rsp = 1; m_rsp_rd = 1;
              m_rdata = exp_mem.exists(int'(m_addr)) ? exp_mem[int'(m_addr)]
                                                      : blank_val(int'(m_addr));
            end
            3: begin m_mode = 4; m_cnt = E_REC; end
            default: begin
              if (m_mode == 4) begin m_rsp = 1; m_rsp_rd = 0; end
              m_mode = 0;
            end
          endcase
        end
      end

      case (m_mode)
        0: tag = "R1";
        1: tag = "R3";
        2: tag = "R4";
        3: tag = "R5";
        default: tag = "R6";
      endcase
      chk(req_ready == (m_mode == 0), "R2", "req_ready", req_ready, m_mode == 0);
      chk(mem_cs_n == !(m_mode == 1 || m_mode == 3), tag, "mem_cs_n", mem_cs_n,
          !(m_mode == 1 || m_mode == 3));
      chk(mem_cs == (m_mode == 1 || m_mode == 3), tag, "mem_cs", mem_cs,
          (m_mode == 1 || m_mode == 3));
      chk(mem_oe_n == (m_mode != 1), tag, "mem_oe_n", mem_oe_n, m_mode != 1);
      chk(mem_we_n == (m_mode != 3), tag, "mem_we_n", mem_we_n, m_mode != 3);
      chk(mem_dq_oe == (m_mode == 3 || m_mode == 4), tag, "mem_dq_oe", mem_dq_oe,
          (m_mode == 3 || m_mode == 4));
      if (m_mode != 0)
        chk(mem_addr == m_addr, "R7", "mem_addr", int'(mem_addr), int'(m_addr));
      if (m_mode == 3 || m_mode == 4)
        chk(mem_dq_o == m_wdata, "R7", "mem_dq_o", mem_dq_o, m_wdata);
      chk(rsp_valid == m_rsp, m_rsp_rd ? "R3" : "R6", "rsp_valid", rsp_valid, m_rsp);
      if (m_rsp && m_rsp_rd)
        chk(rsp_rdata == m_rdata, "R3", "rsp_rdata", rsp_rdata, m_rdata);
    end
    // Snapshot of what the next rising edge will see.
    s_valid = req_valid; s_write = req_write; s_addr = req_addr; s_wdata = req_wdata;
  end

  // Caller stands just after a rising edge.
  task automatic send(input bit wr, input logic [16:0] a, input logic [7:0] d,
                      input bit keep);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    // R2: scramble the inputs while the access runs
    req_addr = ~a; req_wdata = ~d; req_write = ~wr;
    if (!keep) req_valid = 1'b0;
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin
    int lcg;
    #(CLK_NS * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lcg;
    lcg = 32'h1234567;
    gap(3);
    // R1: reset state
    chk(mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready,
        "R1", "pins in reset", {mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
    rst_n = 1'b1;
    gap(3);
    send(1, 17'h00010, 8'h3C, 0);       // R5 R6 single write
    gap(2);
    send(0, 17'h00010, 8'h00, 0);       // R3 R4 read back
    gap(2);
    send(0, 17'h1ABCD, 8'h00, 0);       // R3 unwritten location
    send(1, 17'h00000, 8'h11, 1);       // back-to-back writes, lowest location
    send(1, 17'h1FFFF, 8'hEE, 1);       // highest location
    send(0, 17'h1FFFF, 8'h00, 1);       // read right after write completion
    send(1, 17'h00020, 8'h77, 1);       // R8 write right after read
    send(0, 17'h00000, 8'h00, 1);
    send(0, 17'h00020, 8'h00, 0);
    for (int i = 0; i < 40; i++) begin
      bit wr;
      lcg = lcg * 1103515245 + 12345;
      wr = lcg[20];
      send(wr, {9'h0, 8'(lcg >> 8)} & 17'h0003F, 8'(lcg >> 16), lcg[22]);
      if (lcg[23]) gap(lcg[26:25]);
    end
    req_valid = 1'b0;
    gap(20);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule